// File: doc/BRIEF.md
# Clockless Read Handshake Memory Responder

This block is the memory end of a four-phase read handshake on a shared, multiplexed set of lines. A requester places a word address on the shared lines and raises its request. The responder captures the address, acknowledges it, and starts its internal word fetch at once. It then finishes the release exchange with the requester while that fetch is still running. It presents the data word and its ready flag only when both the fetch and the release exchange are complete. The requester's own acknowledge then closes the transaction.

The request and acknowledge inputs come from logic with no common clock, so each passes through a two-flop synchroniser before the sequencer sees it. The fetch latency is a runtime input counted in clocks. A value of zero means the word is available as soon as the release exchange ends. The storage is a small word-indexed array with a side port for loading test contents. An address outside the array still completes the handshake and returns a word of all ones.

Top module: `abus_mem_resp`

## Requirements
- R1: After reset, `ack_o`, `rdy_o` and `oe_o` are low and `bus_o` is all zeros.
- R2: When the synchronised request is high in the idle state, the responder captures `bus_i` as the word address and raises `ack_o`.
- R3: `ack_o` falls only after the synchronised request has been seen low, and never while the request is still high.
- R4: `ack_o` and `rdy_o` are never high together. `rdy_o` rises only after `ack_o` has fallen and the fetch countdown has reached zero. The delay from `ack_o` rising to `rdy_o` rising is therefore the larger of the two paths, not their sum. With the bench's requester, that delay is max(latency+1, 4) clocks.
- R5: While `rdy_o` is high, `oe_o` is high and `bus_o` holds the stored word at the captured address, unchanged.
- R6: After the synchronised peer acknowledge is seen high, `rdy_o` and `oe_o` fall and `bus_o` returns to zero.
- R7: A new request is not answered until the peer acknowledge has been seen low after the data phase. A request raised while that acknowledge is still high leaves `ack_o` low.
- R8: A captured address whose full 32-bit value is not below the array depth returns 32'hFFFF_FFFF, and the handshake completes normally.
- R9: A cycle with `pre_we_i` high writes `pre_data_i` into the word at `pre_addr_i`; later reads of that word return it.
- R10: `lat_i` is sampled when the address is captured and loads a down-counter that steps once per clock during the release and wait phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request from the requester (unsynchronised) |
| peer_ack_i | input | 1 | Requester's acknowledge of the data word (unsynchronised) |
| bus_i | input | 32 | Shared lines as seen by the responder (address phase) |
| bus_o | output | 32 | Data word driven onto the shared lines |
| oe_o | output | 1 | Drive enable for `bus_o` |
| ack_o | output | 1 | Responder acknowledge of the request |
| rdy_o | output | 1 | Data word valid on the shared lines |
| lat_i | input | 8 | Fetch latency in clocks |
| pre_we_i | input | 1 | Side-port write strobe |
| pre_addr_i | input | 4 | Side-port word index |
| pre_data_i | input | 32 | Side-port write data |

## Verification
The handshake is run with latency zero, small and large, so the measured ack-to-ready delay shows whether the release path or the fetch countdown sets the timing. A latency equal to the release path separates a correct maximum from a sum or an off-by-one. Addresses inside the array, just past it, and with only a high bit set distinguish a full-width range test from a truncated index. A request raised while the peer acknowledge is still high checks that the responder waits for the final acknowledge to fall before answering.

// File: rtl/abus_resp_pkg.sv
package abus_resp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REL  = 3'd1,
    ST_ACC  = 3'd2,
    ST_SHOW = 3'd3,
    ST_DROP = 3'd4
  } resp_state_t;
endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/abus_store.sv
module abus_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/abus_timer.sv
module abus_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             zero_o
);
  logic [LAT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = lat_i;
    else if (run_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i || run_i) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R10
  lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(lat_i));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> cnt_q != '0);
endmodule

// File: rtl/abus_seq.sv
module abus_seq
  import abus_resp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              ack_s,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              zero_i,
  output logic              load_o,
  output logic              run_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              ack_o,
  output logic              rdy_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] bus_o
);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(DEPTH);

  resp_state_t       st_q, st_d;
  logic              ack_q, ack_d, rdy_q, rdy_d, oe_q, oe_d;
  logic [DATA_W-1:0] dat_q, dat_d, addr_q;
  logic              hit;

  assign hit = (addr_q < LIMIT);

  always_comb begin
    st_d   = st_q;
    ack_d  = ack_q;
    rdy_d  = rdy_q;
    oe_d   = oe_q;
    dat_d  = dat_q;
    load_o = 1'b0;
    run_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_s) begin
        load_o = 1'b1;
        ack_d  = 1'b1;
        st_d   = ST_REL;
      end
      ST_REL: begin
        run_o = !zero_i;
        if (!req_s) begin
          ack_d = 1'b0;
          st_d  = ST_ACC;
        end
      end
      ST_ACC: begin
        if (zero_i) begin
          rdy_d = 1'b1;
          oe_d  = 1'b1;
          dat_d = hit ? rd_data_i : '1;
          st_d  = ST_SHOW;
        end else begin
          run_o = 1'b1;
        end
      end
      ST_SHOW: if (ack_s) begin
        rdy_d = 1'b0;
        oe_d  = 1'b0;
        dat_d = '0;
        st_d  = ST_DROP;
      end
      ST_DROP: if (!ack_s) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      rdy_q <= 1'b0;
      oe_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
      rdy_q <= rdy_d;
      oe_q  <= oe_d;
      dat_q <= dat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_o) addr_q <= bus_i;
  end

  assign rd_addr_o = addr_q[ADDR_W-1:0];
  assign ack_o     = ack_q;
  assign rdy_o     = rdy_q;
  assign oe_o      = oe_q;
  assign bus_o     = dat_q;

  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s));

  // R3
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_s));

  // R4
  ack_rdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && rdy_o));

  // R5
  drive_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> oe_o);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && $past(rdy_o)) |-> $stable(bus_o));

  // R6
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(ack_s));
endmodule

// File: rtl/abus_mem_resp.sv
module abus_mem_resp #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LAT_W  = 8,
  parameter int SYNC_N = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              peer_ack_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              oe_o,
  output logic              ack_o,
  output logic              rdy_o,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              pre_we_i,
  input  logic [ADDR_W-1:0] pre_addr_i,
  input  logic [DATA_W-1:0] pre_data_i
);
  logic [1:0]        sync_q;
  logic              load, run, zero;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  abus_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({peer_ack_i, req_i}), .q_o(sync_q)
  );

  abus_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we_i(pre_we_i), .waddr_i(pre_addr_i), .wdata_i(pre_data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  abus_timer #(.LAT_W(LAT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(run),
    .lat_i(lat_i), .zero_o(zero)
  );

  abus_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_s(sync_q[0]), .ack_s(sync_q[1]),
    .bus_i(bus_i), .rd_data_i(rd_data), .zero_i(zero),
    .load_o(load), .run_o(run), .rd_addr_o(rd_addr),
    .ack_o(ack_o), .rdy_o(rdy_o), .oe_o(oe_o), .bus_o(bus_o)
  );
endmodule

// File: tb/abus_mem_resp_test.sv
module abus_mem_resp_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, peer_ack_i = 1'b0;
  logic [31:0] bus_i = '0;
  logic [31:0] bus_o;
  logic        oe_o, ack_o, rdy_o;
  logic [7:0]  lat_i = '0;
  logic        pre_we_i = 1'b0;
  logic [3:0]  pre_addr_i = '0;
  logic [31:0] pre_data_i = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  abus_mem_resp uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .peer_ack_i(peer_ack_i),
    .bus_i(bus_i), .bus_o(bus_o), .oe_o(oe_o), .ack_o(ack_o), .rdy_o(rdy_o),
    .lat_i(lat_i), .pre_we_i(pre_we_i), .pre_addr_i(pre_addr_i),
    .pre_data_i(pre_data_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: expected outputs per clock
  logic [31:0] exp_mem [DEPTH];
  int          ph;
  int          m_cnt;
  logic [31:0] m_addr, m_data;
  logic        m_ack, m_rdy, m_oe;
  logic        rs1, rs2, as1, as2, seen_r, seen_a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_cnt = 0; m_addr = '0; m_data = '0;
      m_ack = 0; m_rdy = 0; m_oe = 0;
      rs1 = 0; rs2 = 0; as1 = 0; as2 = 0;
    end else begin
      seen_r = rs2; seen_a = as2;
      rs2 = rs1; rs1 = req_i;
      as2 = as1; as1 = peer_ack_i;
      case (ph)
        0: if (seen_r) begin m_addr = bus_i; m_cnt = int'(lat_i); m_ack = 1; ph = 1; end
        1: begin
          if (m_cnt > 0) m_cnt--;
          if (!seen_r) begin m_ack = 0; ph = 2; end
        end
        2: if (m_cnt == 0) begin
          m_rdy = 1; m_oe = 1;
          m_data = (m_addr < 32'(DEPTH)) ? exp_mem[m_addr[3:0]] : 32'hFFFF_FFFF;
          ph = 3;
        end else m_cnt--;
        3: if (seen_a) begin m_rdy = 0; m_oe = 0; m_data = '0; ph = 4; end
        default: if (!seen_a) ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ack_o == m_ack, "R2/R3 ack_o per-clock", 32'(ack_o), 32'(m_ack));
      chk(rdy_o == m_rdy, "R4 rdy_o per-clock", 32'(rdy_o), 32'(m_rdy));
      chk(oe_o == m_oe, "R5 oe_o per-clock", 32'(oe_o), 32'(m_oe));
      chk(bus_o == m_data, "R5 bus_o per-clock", bus_o, m_data);
    end
  end

  task automatic preload(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    pre_we_i = 1'b1; pre_addr_i = a; pre_data_i = d;
    exp_mem[a] = d;
    @(negedge clk);
    pre_we_i = 1'b0;
  endtask

  // One read; exp_delay < 0 skips the delay check; hold_next keeps
  // peer_ack high and raises a new request before dropping it.
  task automatic txn(input logic [31:0] addr, input logic [31:0] exp,
                     input int exp_delay, input bit hold_next,
                     input logic [31:0] next_addr);
    int d;
    @(negedge clk);
    bus_i = addr; req_i = 1'b1;
    while (!ack_o) @(negedge clk);
    bus_i = 32'hA5A5_5A5A; req_i = 1'b0;
    d = 0;
    while (!rdy_o) begin
      @(negedge clk);
      d++;
    end
    chk(ack_o == 1'b0, "R4 ack low at data", 32'(ack_o), 32'd0);
    if (exp_delay >= 0) chk(d == exp_delay, "R4 ack-to-ready delay", 32'(d), 32'(exp_delay));
    chk(bus_o == exp && oe_o, "R5/R8 returned word", bus_o, exp);
    repeat (3) @(negedge clk);
    chk(bus_o == exp && rdy_o, "R5 word held", bus_o, exp);
    peer_ack_i = 1'b1;
    while (rdy_o) @(negedge clk);
    chk(oe_o == 1'b0 && bus_o == '0, "R6 release after peer ack", {31'd0, oe_o}, 32'd0);
    if (hold_next) begin
      bus_i = next_addr; req_i = 1'b1;
      repeat (8) @(negedge clk);
      chk(ack_o == 1'b0, "R7 request ignored while peer ack high", 32'(ack_o), 32'd0);
    end
    peer_ack_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ack_o == 0 && rdy_o == 0 && oe_o == 0, "R1 reset controls",
        {29'd0, ack_o, rdy_o, oe_o}, 32'd0);
    chk(bus_o == '0, "R1 reset bus", bus_o, 32'd0);
    rst_n = 1'b1;
    // R9 preload all words
    for (int i = 0; i < DEPTH; i++) preload(4'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101);
    preload(4'd5, 32'hCAFE_F00D);

    lat_i = 8'd0;  txn(32'd5,  32'hCAFE_F00D, 4, 1'b0, '0);                // R4 release path dominates, R9
    lat_i = 8'd2;  txn(32'd1,  exp_mem[1], 4, 1'b0, '0);                   // R4
    lat_i = 8'd3;  txn(32'd15, exp_mem[15], 4, 1'b0, '0);                  // R4 equal paths, max not sum
    lat_i = 8'd5;  txn(32'd0,  exp_mem[0], 6, 1'b0, '0);                   // R10 latency path
    lat_i = 8'd40; txn(32'd7,  exp_mem[7], 41, 1'b0, '0);                  // R10 long fetch
    lat_i = 8'd1;  txn(32'd16, 32'hFFFF_FFFF, 4, 1'b0, '0);                // R8 just past end
    lat_i = 8'd1;  txn(32'h8000_0003, 32'hFFFF_FFFF, -1, 1'b0, '0);        // R8 high bit only
    lat_i = 8'd2;  txn(32'd9,  exp_mem[9], -1, 1'b1, 32'd10);              // R7
    txn(32'd10, exp_mem[10], -1, 1'b0, '0);                                // R7 answered after drop
    preload(4'd10, 32'h0BAD_BEEF);                                         // R9 overwrite
    lat_i = 8'd255; txn(32'd10, 32'h0BAD_BEEF, 256, 1'b0, '0);             // R9, R10 max latency

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule